// File: doc/BRIEF.md
# Decoded-Instruction Cache with Hashed Index

This block keeps the results of earlier instruction decodes so that a fetch unit can skip the decoder when it returns to an address it has already seen. A lookup presents a program counter. In the same cycle the block reports exactly one of three outcomes: a hit, which comes with the stored decoded word; a miss; or an out-of-bounds rejection when the address lies at or beyond the configured memory size.

After the decoder finishes work on a missed address, it writes the address and the decoded word back through the fill port. A fill is accepted only when its decode-success flag is set. The storage is direct-mapped with one entry per slot. The slot is chosen by mixing shifted program-counter bits with XOR, not by taking the low bits directly. Each slot keeps the complete program counter as its tag. A flush input empties the whole cache in one cycle.

Top module: `ic_decoded_cache`

## Requirements
- R1: The slot index is formed by taking h = pc >> 1 and keeping the low log2(ENTRIES) bits of (h >> 5) XOR (h << 1). With the default 2048 entries, pc 0x0 and pc 0x2082 share slot 0 and evict each other. Pc 0x0 and pc 0x2 land in different slots and can both be resident.
- R2: When lkp_valid is high, lkp_hit is high in that same cycle exactly when the slot holds an entry whose tag equals the full 64-bit lkp_pc. On a hit, lkp_data is the stored word.
- R3: When lkp_valid is high and lkp_pc >= MEM_SIZE, lkp_oob is high and both lkp_hit and lkp_miss are low. The default MEM_SIZE is 0x400000, so pc 0x3FFFFE is in range and pc 0x400000 is out of bounds.
- R4: When lkp_valid is high, exactly one of lkp_hit, lkp_miss and lkp_oob is high. When lkp_valid is low, all three are low.
- R5: A fill writes its slot only when fill_en, fill_ok and fill_pc < MEM_SIZE are all high in the same cycle. A fill with fill_ok low leaves the cache unchanged.
- R6: A fill into a slot that is already occupied replaces the tag and the data unconditionally.
- R7: When a fill and a lookup address the same slot in the same cycle, the lookup returns the contents from before the fill. The new contents are visible from the next cycle on.
- R8: flush empties every slot at the next clock edge and wins over a fill in the same cycle.
- R9: After reset every slot is empty. lkp_data reads zero whenever lkp_hit is low.
- R10: After an accepted fill, a lookup of the same pc in the next cycle hits and returns the filled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the cache |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_pc | input | 64 | Program counter to look up |
| lkp_hit | output | 1 | Lookup found a matching entry |
| lkp_miss | output | 1 | Lookup in range but no matching entry |
| lkp_oob | output | 1 | Lookup address at or above MEM_SIZE |
| lkp_data | output | 64 | Decoded word on a hit, zero otherwise |
| fill_en | input | 1 | Fill request |
| fill_ok | input | 1 | The decode that produced the fill succeeded |
| fill_pc | input | 64 | Program counter of the fill |
| fill_data | input | 64 | Decoded word to store |
| flush | input | 1 | Empty every slot |

## Verification
The bench targets index aliasing in three ways. The pair 0x0/0x2082 collides only under the XOR hash, so a plain low-bit index would let both entries live side by side. Random addresses offset by 1<<17 collide under any correct hash; a hash that mixed in higher bits would keep both. Tag width is exercised with same-slot addresses that differ only in high bits, which a design that compared a truncated tag would report as false hits. The bench also checks a fill that coincides with a lookup (a write-through path would return the new word too early), a fill with a failed decode (a design that ignored fill_ok would start hitting), flush racing a fill (the wrong priority leaves one live entry), and the exact MEM_SIZE boundary (an off-by-one turns the last legal address into a rejection).

// File: rtl/ic_pkg.sv
package ic_pkg;
  // Mixes a program counter into a slot number; the caller keeps the low bits.
  function automatic logic [63:0] ic_hash_mix(input logic [63:0] pc, input int unsigned hi_sh);
    logic [63:0] half;
    half = pc >> 1;
    return (half >> hi_sh) ^ (half << 1);
  endfunction
endpackage

// File: rtl/ic_index_hash.sv
module ic_index_hash #(
  parameter int unsigned PC_W     = 64,
  parameter int unsigned IDX_W    = 11,
  parameter int unsigned HI_SHIFT = 5
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  import ic_pkg::*;
  assign idx = IDX_W'(ic_hash_mix(64'(pc), HI_SHIFT));
endmodule

// File: rtl/ic_slot_store.sv
module ic_slot_store #(
  parameter int unsigned ENTRIES = 2048,
  parameter int unsigned PC_W    = 64,
  parameter int unsigned DATA_W  = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PC_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_live,
  output logic [PC_W-1:0]   rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  logic [ENTRIES-1:0] live_q;
  logic [PC_W-1:0]    tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic               commit;

  // Clearing outranks writing.
  assign commit = wr_en && !clr_all;

  always_ff @(posedge clk) begin
    if (!rst_n)       live_q <= '0;
    else if (clr_all) live_q <= '0;
    else if (commit)  live_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_live = live_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  // R5 / R6: a committed write leaves its slot occupied with the written tag
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
  // R8: clearing empties every slot
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> live_q == '0);
endmodule

// File: rtl/ic_decoded_cache.sv
module ic_decoded_cache #(
  parameter int unsigned ENTRIES   = 2048,
  parameter int unsigned PC_W      = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned HI_SHIFT  = 5,
  parameter logic [63:0] MEM_SIZE  = 64'h0040_0000,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              lkp_hit,
  output logic              lkp_miss,
  output logic              lkp_oob,
  output logic [DATA_W-1:0] lkp_data,
  input  logic              fill_en,
  input  logic              fill_ok,
  input  logic [PC_W-1:0]   fill_pc,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              flush
);
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              rd_live;
  logic [PC_W-1:0]   rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              lkp_in_range, fill_in_range, fill_fire, tag_match;

  ic_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HI_SHIFT(HI_SHIFT)) u_rd_hash (
    .pc(lkp_pc), .idx(rd_idx));
  ic_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HI_SHIFT(HI_SHIFT)) u_wr_hash (
    .pc(fill_pc), .idx(wr_idx));

  assign lkp_in_range  = 64'(lkp_pc) < MEM_SIZE;
  assign fill_in_range = 64'(fill_pc) < MEM_SIZE;
  assign fill_fire     = fill_en && fill_ok && fill_in_range;

  ic_slot_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(flush),
    .wr_en(fill_fire), .wr_idx(wr_idx), .wr_tag(fill_pc), .wr_data(fill_data),
    .rd_idx(rd_idx), .rd_live(rd_live), .rd_tag(rd_tag), .rd_data(rd_data));

  assign tag_match = rd_live && (rd_tag == lkp_pc);
  assign lkp_oob   = lkp_valid && !lkp_in_range;
  assign lkp_hit   = lkp_valid && lkp_in_range && tag_match;
  assign lkp_miss  = lkp_valid && lkp_in_range && !tag_match;
  assign lkp_data  = lkp_hit ? rd_data : '0;

  // R4: one outcome per valid lookup, none otherwise
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lkp_hit, lkp_miss, lkp_oob}) == (lkp_valid ? 1 : 0));
  // R3: out-of-range addresses never hit
  a_r3_oob_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && 64'(lkp_pc) >= MEM_SIZE) |-> (lkp_oob && !lkp_hit && !lkp_miss));
  // R9: data bus idle unless hitting
  a_r9_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_hit |-> lkp_data == '0);
  // R8: nothing hits right after a flush
  a_r8_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lkp_hit);
  // R10: an accepted fill is hit by the next lookup of the same pc
  a_r10_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !flush) ##1 (lkp_valid && lkp_pc == $past(fill_pc))
      |-> (lkp_hit && lkp_data == $past(fill_data)));
endmodule

// File: tb/tb_ic_decoded_cache.sv
module tb_ic_decoded_cache;
  localparam int  CLK_PERIOD = 10;
  localparam int  N          = 2048;
  localparam logic [63:0] MEM = 64'h0040_0000;

  logic clk = 0, rst_n = 0;
  logic lkp_valid = 0, fill_en = 0, fill_ok = 0, flush = 0;
  logic [63:0] lkp_pc = 0, fill_pc = 0, fill_data = 0, lkp_data;
  logic lkp_hit, lkp_miss, lkp_oob;

  int checks = 0, failures = 0;
  logic        m_live [N];
  logic [63:0] m_tag  [N];
  logic [63:0] m_data [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  ic_decoded_cache dut (.clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .lkp_hit(lkp_hit), .lkp_miss(lkp_miss), .lkp_oob(lkp_oob), .lkp_data(lkp_data),
    .fill_en(fill_en), .fill_ok(fill_ok), .fill_pc(fill_pc), .fill_data(fill_data),
    .flush(flush));

  // Bit-wise restatement of the slot hash: bit i = h[i+5] ^ h[i-1].
  function automatic int slot_of(input logic [63:0] pc);
    logic [63:0] h;
    int s;
    h = pc >> 1;
    s = 0;
    for (int i = 0; i < 11; i++)
      s[i] = h[i+5] ^ ((i > 0) ? h[i-1] : 1'b0);
    return s;
  endfunction

  task automatic check(input string req, input logic [66:0] got, input logic [66:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Present inputs, compare outputs mid-cycle against the model, then clock.
  task automatic cycle(input logic lv, input logic [63:0] lpc, input logic fe, input logic fo,
                       input logic [63:0] fpc, input logic [63:0] fd, input logic fl,
                       input string req);
    logic eh, em, eo;
    logic [63:0] ed;
    int s;
    lkp_valid = lv; lkp_pc = lpc; fill_en = fe; fill_ok = fo;
    fill_pc = fpc; fill_data = fd; flush = fl;
    #(CLK_PERIOD/4);
    s  = slot_of(lpc);
    eo = lv && (lpc >= MEM);
    eh = lv && !eo && m_live[s] && m_tag[s] == lpc;
    em = lv && !eo && !eh;
    ed = eh ? m_data[s] : 64'd0;
    check(req, {lkp_hit, lkp_miss, lkp_oob, lkp_data}, {eh, em, eo, ed});
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_live[i] = 1'b0;
    end else if (fe && fo && fpc < MEM) begin
      s = slot_of(fpc);
      m_live[s] = 1'b1; m_tag[s] = fpc; m_data[s] = fd;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [63:0] pc, input string req);
    cycle(1, pc, 0, 0, 0, 0, 0, req);
  endtask
  task automatic fill(input logic [63:0] pc, input logic [63:0] d);
    cycle(0, 0, 1, 1, pc, d, 0, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] pool [16];
    int u;
    void'($urandom(32'h1c5e_0a17));
    for (int i = 0; i < N; i++) begin m_live[i] = 0; m_tag[i] = '1; m_data[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state is empty
    look(64'h0, "R9");
    look(64'h1234, "R9");
    cycle(0, 0, 0, 0, 0, 0, 0, "R4");

    // R10 / R2: fill then hit
    fill(64'h0, 64'hAAAA_0000_0000_0001);
    look(64'h0, "R10");
    // R1: distinct slots coexist
    fill(64'h2, 64'hBBBB);
    look(64'h0, "R1");
    look(64'h2, "R1");
    // R1: hash-only alias evicts
    fill(64'h2082, 64'hCCCC);
    look(64'h0, "R1");
    look(64'h2082, "R1");
    // R6: overwrite same pc
    fill(64'h2082, 64'hDDDD);
    look(64'h2082, "R6");
    // R2: same slot, differing high tag bits, no hit
    look(64'h2082 + (64'h1 << 17), "R2");
    // R5: failed decode ignored
    cycle(0, 0, 1, 0, 64'h100, 64'hEEEE, 0, "R5");
    look(64'h100, "R5");
    // R7: fill and lookup same slot, old content first
    cycle(1, 64'h2082, 1, 1, 64'h0, 64'h7777, 0, "R7");
    look(64'h0, "R7");
    // R3: boundary
    fill(MEM - 2, 64'h5151);
    look(MEM - 2, "R3");
    look(MEM, "R3");
    look(64'hFFFF_FFFF_FFFF_FFFE, "R3");
    cycle(0, 0, 1, 1, MEM, 64'h99, 0, "R5");
    look(MEM, "R3");
    // R8: flush wins over fill
    cycle(0, 0, 1, 1, 64'h400, 64'h4242, 1, "R8");
    look(64'h400, "R8");
    look(64'h2, "R8");
    look(MEM - 2, "R8");

    // Random mix with built-in aliases
    for (int i = 0; i < 16; i++) begin
      pool[i] = {42'd0, $urandom(), 1'b0} % MEM;
      if (i % 4 == 3) pool[i] = (pool[i-1] + (64'h1 << 17)) % MEM;
    end
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] lp, fp;
      u  = $urandom % 100;
      lp = (u < 5) ? MEM + 2 * ($urandom % 8) : pool[$urandom % 16];
      fp = pool[$urandom % 16];
      cycle($urandom % 8 != 0, lp, $urandom % 3 == 0, $urandom % 5 != 0, fp,
            {$urandom(), $urandom()}, $urandom % 200 == 0, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule